// File: doc/BRIEF.md
# Manchester Frame Decoder with Identifier Match

This block recovers framed data from a demodulated Manchester line that is sampled by a much faster system clock. It synchronises the raw line and times the gaps between its edges against a programmable half-bit length. From that timing it locks onto the mid-bit transitions, which carry the data. Once locked, it slides the decoded bits through a window until they equal a programmed identifier. It then expects a four-bit header of selectable polarity. After the header it hands every payload bit out with a one-cycle strobe.

Bit encoding: a mid-bit rising edge is a 1 and a falling edge is a 0, so the decoded bit is the line level just after its mid-bit edge. Any run of valid bits may come before the identifier and act as a preamble. A message ends when the line deliberately breaks the Manchester code and stays at one level for two whole bit periods. That event gives a one-cycle end pulse and sends the decoder back to searching.

Top module: `mfd_decoder`

## Requirements
- R1: While reset is high, and on the first edge after it, `id_match`, `hdr_found`, `dstrobe` and `eom` are all low.
- R2: After a preamble of alternating bits of any length of two or more, an identifier whose bits arrive MSB first and equal `id_word` raises `id_match`.
- R3: A stream whose identifier differs from `id_word` never raises `id_match`, gives no `dstrobe` and no `eom`.
- R4: The four bits after the identifier must be 0,1,0,1 in arrival order when `hdr_inv` is 0, or 1,0,1,0 when `hdr_inv` is 1. On a match `hdr_found` rises. Any other header drops `id_match`, and no payload is emitted.
- R5: Each payload bit that follows the header is given on `dout` with a one-cycle `dstrobe`, in arrival order, starting with the first bit after the header.
- R6: When the line holds one level for two bit periods after the payload, whether that level equals the last bit or not, `eom` pulses for exactly one cycle and `id_match` and `hdr_found` fall.
- R7: Frames whose high/low split within each bit is anywhere from 45%/55% to 55%/45% decode the same as 50%/50% frames.
- R8: The half-bit length in system clocks is set by `half_period`. Frames at different rates decode correctly when `half_period` matches their rate.
- R9: A mid-bit edge that comes more than 25% of a bit period later than expected drops lock. No further strobes come, `hdr_found` falls and no `eom` is produced for that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Raw demodulated Manchester line (asynchronous) |
| half_period | input | CNT_W | Half-bit length in system clock cycles |
| id_word | input | ID_BITS | Identifier to match, MSB received first |
| hdr_inv | input | 1 | Selects header 1010 instead of 0101 |
| dout | output | 1 | Recovered payload bit |
| dstrobe | output | 1 | One-cycle pulse marking a valid `dout` |
| id_match | output | 1 | Identifier matched, frame in progress |
| hdr_found | output | 1 | Header matched, payload in progress |
| eom | output | 1 | One-cycle end-of-message pulse |

## Verification
The properties assume that `half_period` and `hdr_inv` stay constant while a frame is in flight. They also assume that `din` changes no faster than the synchroniser can follow. The stimulus changes rate and polarity only while the line is idle after an end of message, and it holds each line level for many system clocks. The identifiers are chosen so that they cannot appear inside the alternating preamble, so the first possible match is always the intended one. Distortion of the duty cycle and a single late mid-bit edge are the only timing faults injected, and each lies clearly inside or clearly outside the ±25% window.

// File: rtl/mfd_pkg.sv
package mfd_pkg;
  typedef enum logic [1:0] {ST_SRCH, ST_ID, ST_HDR, ST_DATA} mfd_state_e;
  localparam int HDR_BITS = 4;
  localparam logic [HDR_BITS-1:0] HDR_BASE = 4'b0101;
endpackage

// File: rtl/mfd_sync.sv
module mfd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic lvl_o,
  output logic edg_o
);
  logic [STAGES:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= '0;
    else     sr <= {sr[STAGES-1:0], din};
  end

  assign lvl_o = sr[STAGES-1];
  assign edg_o = sr[STAGES] ^ sr[STAGES-1];
endmodule

// File: rtl/mfd_timer.sv
module mfd_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             edg_i,
  input  logic             mclr_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             acq_o,
  output logic             mid_o,
  output logic             slip_o,
  output logic             gap_o
);
  localparam int EW = CNT_W + 2;

  logic [CNT_W-1:0] gcnt, mcnt;
  logic [EW-1:0]    h, lo, hi, th, gx, mx;

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt <= '0;
      mcnt <= '0;
    end else begin
      if (edg_i)           gcnt <= '0;
      else if (~&gcnt)     gcnt <= gcnt + 1'b1;
      if (mclr_i)          mcnt <= '0;
      else if (~&mcnt)     mcnt <= mcnt + 1'b1;
    end
  end

  always_comb begin
    h      = EW'(half_i);
    lo     = h + (h >> 1);
    hi     = (h << 1) + (h >> 1);
    th     = h + (h << 1);
    gx     = EW'(gcnt);
    mx     = EW'(mcnt);
    acq_o  = edg_i && (gx >= lo) && (gx <= hi);
    mid_o  = edg_i && (mx >= lo) && (mx <= hi);
    slip_o = edg_i && (mx > hi);
    gap_o  = !edg_i && (gx > th);
  end
endmodule

// File: rtl/mfd_frame.sv
module mfd_frame
  import mfd_pkg::*;
#(
  parameter int ID_BITS = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lvl_i,
  input  logic               acq_i,
  input  logic               mid_i,
  input  logic               slip_i,
  input  logic               gap_i,
  input  logic [ID_BITS-1:0] id_word,
  input  logic               hdr_inv,
  output logic               mclr_o,
  output logic               dout,
  output logic               dstrobe,
  output logic               id_match,
  output logic               hdr_found,
  output logic               eom
);
  localparam int IDC_W = $clog2(ID_BITS + 1);
  localparam int HC_W  = $clog2(HDR_BITS + 1);

  mfd_state_e          st;
  logic [ID_BITS-1:0]  win, win_nx;
  logic [IDC_W-1:0]    idc;
  logic [HDR_BITS-1:0] hsh, hsh_nx, hdr_pat;
  logic [HC_W-1:0]     hc;

  always_comb begin
    win_nx  = {win[ID_BITS-2:0], lvl_i};
    hsh_nx  = {hsh[HDR_BITS-2:0], lvl_i};
    hdr_pat = hdr_inv ? ~HDR_BASE : HDR_BASE;
    mclr_o  = (st == ST_SRCH) ? acq_i : mid_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_SRCH; win <= '0; idc <= '0; hsh <= '0; hc <= '0;
      dout <= 1'b0; dstrobe <= 1'b0; id_match <= 1'b0;
      hdr_found <= 1'b0; eom <= 1'b0;
    end else begin
      dstrobe <= 1'b0;
      eom     <= 1'b0;
      case (st)
        ST_SRCH: if (acq_i) begin
          win <= win_nx;
          idc <= IDC_W'(1);
          st  <= ST_ID;
        end
        ST_ID: begin
          if (slip_i || gap_i) begin
            st <= ST_SRCH; idc <= '0;
          end else if (mid_i) begin
            win <= win_nx;
            if (idc != IDC_W'(ID_BITS)) idc <= idc + 1'b1;
            if (win_nx == id_word && idc >= IDC_W'(ID_BITS - 1)) begin
              st <= ST_HDR; id_match <= 1'b1; hc <= '0;
            end
          end
        end
        ST_HDR: begin
          if (slip_i || gap_i) begin
            st <= ST_SRCH; idc <= '0; id_match <= 1'b0;
          end else if (mid_i) begin
            hsh <= hsh_nx;
            hc  <= hc + 1'b1;
            if (hc == HC_W'(HDR_BITS - 1)) begin
              if (hsh_nx == hdr_pat) begin
                st <= ST_DATA; hdr_found <= 1'b1;
              end else begin
                st <= ST_SRCH; idc <= '0; id_match <= 1'b0;
              end
            end
          end
        end
        ST_DATA: begin
          if (gap_i || slip_i) begin
            st <= ST_SRCH; idc <= '0;
            id_match <= 1'b0; hdr_found <= 1'b0;
            eom <= gap_i;
          end else if (mid_i) begin
            dout    <= lvl_i;
            dstrobe <= 1'b1;
          end
        end
        default: st <= ST_SRCH;
      endcase
    end
  end
endmodule

// File: rtl/mfd_decoder.sv
module mfd_decoder #(
  parameter int CNT_W   = 16,
  parameter int ID_BITS = 8,
  parameter int SYNC_N  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               din,
  input  logic [CNT_W-1:0]   half_period,
  input  logic [ID_BITS-1:0] id_word,
  input  logic               hdr_inv,
  output logic               dout,
  output logic               dstrobe,
  output logic               id_match,
  output logic               hdr_found,
  output logic               eom
);
  logic lvl, edg, acq, mid, slip, gap, mclr;

  mfd_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst(rst), .din(din), .lvl_o(lvl), .edg_o(edg)
  );

  mfd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .edg_i(edg), .mclr_i(mclr), .half_i(half_period),
    .acq_o(acq), .mid_o(mid), .slip_o(slip), .gap_o(gap)
  );

  mfd_frame #(.ID_BITS(ID_BITS)) u_frame (
    .clk(clk), .rst(rst), .lvl_i(lvl), .acq_i(acq), .mid_i(mid),
    .slip_i(slip), .gap_i(gap), .id_word(id_word), .hdr_inv(hdr_inv),
    .mclr_o(mclr), .dout(dout), .dstrobe(dstrobe), .id_match(id_match),
    .hdr_found(hdr_found), .eom(eom)
  );
endmodule

// File: rtl/mfd_checker.sv
module mfd_checker (
  input logic clk,
  input logic rst,
  input logic dstrobe,
  input logic id_match,
  input logic hdr_found,
  input logic eom
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!id_match && !hdr_found && !dstrobe && !eom)); // R1
  AST_ID_BEFORE_HDR: assert property (@(posedge clk) disable iff (rst)
    $rose(id_match) |-> !hdr_found); // R2
  AST_HDR_NEEDS_ID: assert property (@(posedge clk) disable iff (rst)
    $rose(hdr_found) |-> $past(id_match) && id_match); // R4
  AST_STROBE_IN_PAYLOAD: assert property (@(posedge clk) disable iff (rst)
    dstrobe |-> (hdr_found && id_match)); // R5
  AST_EOM_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eom |=> !eom); // R6
  AST_EOM_CLOSES_FRAME: assert property (@(posedge clk) disable iff (rst)
    eom |-> (!hdr_found && !id_match && $past(hdr_found) && !dstrobe)); // R6
endmodule

bind mfd_decoder mfd_checker u_chk (
  .clk(clk), .rst(rst), .dstrobe(dstrobe), .id_match(id_match),
  .hdr_found(hdr_found), .eom(eom)
);

// File: tb/sim_mfd_decoder.sv
module sim_mfd_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int ID_BITS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic [CNT_W-1:0] half_period = 16'd20;
  logic [ID_BITS-1:0] id_word = 8'hC5;
  logic hdr_inv = 1'b0;
  logic dout, dstrobe, id_match, hdr_found, eom;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int ncap = 0, neom = 0;
  logic [31:0] capv = '0;
  logic id_seen = 1'b0, hdr_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfd_decoder #(.CNT_W(CNT_W), .ID_BITS(ID_BITS)) u0 (
    .clk(clk), .rst(rst), .din(din), .half_period(half_period),
    .id_word(id_word), .hdr_inv(hdr_inv), .dout(dout), .dstrobe(dstrobe),
    .id_match(id_match), .hdr_found(hdr_found), .eom(eom)
  );

  always @(negedge clk) begin
    if (dstrobe) begin capv = {capv[30:0], dout}; ncap++; end
    if (eom) neom++;
    if (id_match) id_seen = 1'b1;
    if (hdr_found) hdr_seen = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=%0d exp=<190000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    ncap = 0; neom = 0; capv = '0; id_seen = 1'b0; hdr_seen = 1'b0;
  endtask

  task automatic send_bit(input logic b, input int first, input int total);
    din = ~b;
    repeat (first) @(negedge clk);
    din = b;
    repeat (total - first) @(negedge clk);
  endtask

  // Preamble, identifier, header, payload, then a two-bit-period hold.
  task automatic send_frame(input logic [7:0] id, input logic [3:0] hdr,
                            input logic [15:0] pl, input int npl, input int npre,
                            input int duty, input logic eomlvl, input int stretch);
    int t, f;
    t = 2 * int'(half_period);
    f = t * duty / 100;
    for (int i = 0; i < npre; i++) send_bit((i % 2) == 0, f, t);
    for (int i = 7; i >= 0; i--) send_bit(id[i], f, t);
    for (int i = 3; i >= 0; i--) send_bit(hdr[i], f, t);
    for (int i = npl - 1; i >= 0; i--) begin
      if ((npl - 1 - i) == stretch) send_bit(pl[i], int'(half_period) + 12, t + 12);
      else send_bit(pl[i], f, t);
    end
    din = eomlvl;
    repeat (6 * t) @(negedge clk);
  endtask

  function automatic int low_bits(input logic [31:0] v, input int n);
    return int'(v & ((32'd1 << n) - 1));
  endfunction

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1 id_match in reset", int'(id_match), 0);
    chk("R1 hdr_found in reset", int'(hdr_found), 0);
    chk("R1 dstrobe in reset", int'(dstrobe), 0);
    chk("R1 eom in reset", int'(eom), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 outputs after release", int'({id_match, hdr_found, dstrobe, eom}), 0);
  endtask

  task automatic t_good(input string req, input int duty, input int npre,
                        input logic [15:0] pl, input int npl, input logic eomlvl);
    clr_mon();
    send_frame(id_word, hdr_inv ? 4'b1010 : 4'b0101, pl, npl, npre, duty, eomlvl, -1);
    chk({req, " R2 id_match seen"}, int'(id_seen), 1);
    chk({req, " R4 hdr_found seen"}, int'(hdr_seen), 1);
    chk({req, " R5 payload count"}, ncap, npl);
    chk({req, " R5 payload value"}, low_bits(capv, npl), int'(pl));
    chk({req, " R6 eom pulses"}, neom, 1);
    chk({req, " R6 flags cleared"}, int'({id_match, hdr_found}), 0);
  endtask

  task automatic t_bad_id();
    clr_mon();
    send_frame(8'hC4, 4'b0101, 16'h00A5, 8, 6, 50, 1'b0, -1);
    chk("R3 id_match never", int'(id_seen), 0);
    chk("R3 no strobes", ncap, 0);
    chk("R3 no eom", neom, 0);
  endtask

  task automatic t_bad_hdr();
    hdr_inv = 1'b1;
    clr_mon();
    send_frame(id_word, 4'b0101, 16'h0033, 8, 6, 50, 1'b1, -1);
    chk("R4 id matched before bad header", int'(id_seen), 1);
    chk("R4 bad header no hdr_found", int'(hdr_seen), 0);
    chk("R4 bad header no payload", ncap, 0);
    chk("R4 bad header id_match dropped", int'(id_match), 0);
    hdr_inv = 1'b0;
  endtask

  task automatic t_slip();
    clr_mon();
    send_frame(id_word, 4'b0101, 16'h00B6, 8, 6, 50, 1'b0, 4);
    chk("R9 strobes stop at late edge", ncap, 4);
    chk("R9 bits before late edge", low_bits(capv, 4), 4'hB);
    chk("R9 no eom after slip", neom, 0);
    chk("R9 hdr_found low", int'(hdr_found), 0);
  endtask

  initial begin
    t_reset();
    repeat (50) @(negedge clk);
    t_good("basic", 50, 6, 16'h02CE, 10, 1'b1);
    t_good("eom same level", 50, 2, 16'h02CE, 10, 1'b0);
    t_good("long preamble", 50, 14, 16'hA5F0, 16, 1'b1);
    hdr_inv = 1'b1;
    t_good("R4 inverted header", 50, 6, 16'h0019, 6, 1'b0);
    hdr_inv = 1'b0;
    t_bad_hdr();
    t_bad_id();
    t_good("R7 duty 45", 45, 6, 16'h0D2B, 12, 1'b0);
    t_good("R7 duty 55", 55, 6, 16'h0D2B, 12, 1'b1);
    half_period = 16'd12;
    t_good("R8 fast rate", 50, 6, 16'h0137, 9, 1'b0);
    half_period = 16'd40;
    t_good("R8 slow rate", 50, 6, 16'h0137, 9, 1'b1);
    half_period = 16'd20;
    t_slip();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule